// File: doc/BRIEF.md
# Power Management Event Status Register

This block holds a 16-bit word of sticky power-management event flags. Each implemented flag is set by a hardware source and stays set until software writes a 1 to its position. Writing a 0 leaves a flag as it was. Software reads the word back on a plain read port. Bits with no source always read as zero.

Six sources arrive as single-cycle event pulses: wake-up, real-time-clock interrupt, sleep button, power button, button override and firmware release. Two further flags come from built-in detectors. One watches a bank of active-low bus-master request lines and sets its flag when any of them is low. The other watches one selected top bit of a free-running 32-bit timer and sets its flag each time that bit changes value.

An interrupt request is raised when any flag is set while its bit in a separate enable vector is also set. The request is registered.

Top module: `pm_status_reg`

## Requirements
- R1: After a synchronous active-high reset, `rd_data` reads 0000h and `irq` is 0.
- R2: A one-cycle event pulse sets its flag at the next clock edge. The flag positions are wake 15, button override 11, real-time clock 10, sleep button 9, power button 8 and firmware release 5. Several pulses in one cycle set all of their flags.
- R3: A set flag stays set until it is cleared by a write. A write with a 0 in a flag's position leaves that flag unchanged.
- R4: A write (`wr_en` high) clears, at the next edge, exactly the flags whose positions hold 1 in `wr_data`. All other flags keep their values.
- R5: If a flag's source is active in the same cycle as a write that clears that flag, the flag is set after the edge.
- R6: The reserved positions 14:12, 7:6 and 3:1 always read 0, whatever events or writes occur.
- R7: Bit 0 sets when the watched timer bit differs from its value in the previous cycle, in either direction. With `tmr_sel_hi`=0 the watched bit is `tmr_val[23]`; with `tmr_sel_hi`=1 it is `tmr_val[31]`. A change in any bit that is not watched has no effect.
- R8: Bit 4 sets at the next edge when any line of `bm_req_n` is 0 in a cycle. It does not set while all lines are 1.
- R9: `irq` equals the OR over all bits of (flag AND `evt_en`), taken from the values before the previous clock edge. It therefore follows a change one cycle late. Enable bits at reserved positions never raise `irq`.
- R10: Flags set regardless of `evt_en`. The enable vector affects only `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wake_evt | input | 1 | Wake-up event pulse |
| rtc_evt | input | 1 | Real-time-clock interrupt pulse |
| slpbtn_evt | input | 1 | Sleep button event pulse |
| pwrbtn_evt | input | 1 | Power button event pulse |
| ovr_evt | input | 1 | Button override event pulse |
| fw_rel_evt | input | 1 | Firmware-release bit written high |
| bm_req_n | input | NREQ | Active-low bus-master request lines |
| tmr_val | input | TMR_W | Free-running timer value |
| tmr_sel_hi | input | 1 | 1 watches bit 31, 0 watches bit 23 |
| wr_en | input | 1 | Write strobe for clear-by-one |
| wr_data | input | 16 | Write data; a 1 clears that flag |
| evt_en | input | 16 | Interrupt enable per flag |
| rd_data | output | 16 | Current flag word |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that all inputs change synchronously to the clock. The timer-flag property fires only on a cycle where the select input has held its value for the current and the previous cycle. A select change alone is therefore not taken as a watched-bit toggle. The stimulus drives every input on the falling edge. It changes the select only when bits 23 and 31 of the timer value are equal, so a select change never looks like a toggle. Event pulses last exactly one cycle, except in the tests that deliberately hold a source active during a clearing write.

// File: rtl/pmsts_pkg.sv
package pmsts_pkg;

    localparam int STS_W = 16;

    localparam int BIT_WAKE = 15;
    localparam int BIT_OVR  = 11;
    localparam int BIT_RTC  = 10;
    localparam int BIT_SLP  = 9;
    localparam int BIT_PWR  = 8;
    localparam int BIT_GLB  = 5;
    localparam int BIT_BM   = 4;
    localparam int BIT_TMR  = 0;

    localparam logic [STS_W-1:0] IMPL_MASK =
        STS_W'((1 << BIT_WAKE) | (1 << BIT_OVR) | (1 << BIT_RTC) |
               (1 << BIT_SLP)  | (1 << BIT_PWR) | (1 << BIT_GLB) |
               (1 << BIT_BM)   | (1 << BIT_TMR));

    typedef struct packed {
        logic wake;
        logic ovr;
        logic rtc;
        logic slp;
        logic pwr;
        logic glb;
        logic bm;
        logic tmr;
    } pm_src_t;

    function automatic logic [STS_W-1:0] src_to_vec(input pm_src_t s);
        logic [STS_W-1:0] v;
        v = '0;
        v[BIT_WAKE] = s.wake;
        v[BIT_OVR]  = s.ovr;
        v[BIT_RTC]  = s.rtc;
        v[BIT_SLP]  = s.slp;
        v[BIT_PWR]  = s.pwr;
        v[BIT_GLB]  = s.glb;
        v[BIT_BM]   = s.bm;
        v[BIT_TMR]  = s.tmr;
        return v;
    endfunction

endpackage

// File: rtl/pm_evt_detect.sv
module pm_evt_detect #(
    parameter int NREQ   = 8,
    parameter int TMR_W  = 32,
    parameter int LO_BIT = 23,
    parameter int HI_BIT = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NREQ-1:0]  bm_req_n,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic             tmr_sel_hi,
    output logic             bm_hit,
    output logic             tmr_toggle
);
    logic watched;
    logic watched_prev;

    assign watched = tmr_sel_hi ? tmr_val[HI_BIT] : tmr_val[LO_BIT];

    // History flop loads even in reset so the first cycle after reset
    // compares against a real value.
    always_ff @(posedge clk) begin
        watched_prev <= watched;
    end

    assign tmr_toggle = watched ^ watched_prev;
    assign bm_hit     = ~(&bm_req_n);

    // R7: watched bit change with a steady select sets the timer flag
    p_tmr_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        (tmr_sel_hi == $past(tmr_sel_hi)) &&
        ((tmr_sel_hi ? tmr_val[HI_BIT] : tmr_val[LO_BIT]) !=
         (tmr_sel_hi ? $past(tmr_val[HI_BIT]) : $past(tmr_val[LO_BIT])))
        |-> tmr_toggle);

endmodule

// File: rtl/pm_sticky_bank.sv
module pm_sticky_bank
    import pmsts_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STS_W-1:0] set_vec,
    input  logic             wr_en,
    input  logic [STS_W-1:0] wr_data,
    output logic [STS_W-1:0] stat_q
);
    logic [STS_W-1:0] clr_vec;

    assign clr_vec = wr_en ? wr_data : '0;

    for (genvar b = 0; b < STS_W; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_impl
            always_ff @(posedge clk) begin
                if (rst)
                    stat_q[b] <= 1'b0;
                else
                    stat_q[b] <= set_vec[b] | (stat_q[b] & ~clr_vec[b]);
            end
        end else begin : g_rsvd
            assign stat_q[b] = 1'b0;
        end
    end

    // R3: a set flag drops only where a 1 was written
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(stat_q) & ~$past(wr_en ? wr_data : '0)) & ~stat_q) == '0));

    // R4: with no source active, written ones clear their flags
    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (set_vec == '0)) |=> ((stat_q & $past(wr_data)) == '0));

    // R5: an active source always leaves its flag set
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(set_vec & IMPL_MASK)) == $past(set_vec & IMPL_MASK)));

endmodule

// File: rtl/pm_irq_gen.sv
module pm_irq_gen
    import pmsts_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STS_W-1:0] stat,
    input  logic [STS_W-1:0] en,
    output logic             irq_q
);
    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |(stat & en);
    end

    // R9: request follows enabled flags one cycle late
    p_irq_lag_r9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (irq_q == $past(|(stat & en))));

endmodule

// File: rtl/pm_status_reg.sv
module pm_status_reg
    import pmsts_pkg::*;
#(
    parameter int NREQ       = 8,
    parameter int TMR_W      = 32,
    parameter int TMR_LO_BIT = 23,
    parameter int TMR_HI_BIT = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wake_evt,
    input  logic             rtc_evt,
    input  logic             slpbtn_evt,
    input  logic             pwrbtn_evt,
    input  logic             ovr_evt,
    input  logic             fw_rel_evt,
    input  logic [NREQ-1:0]  bm_req_n,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic             tmr_sel_hi,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    input  logic [15:0]      evt_en,
    output logic [15:0]      rd_data,
    output logic             irq
);
    logic             bm_hit;
    logic             tmr_toggle;
    pm_src_t          src;
    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] stat;

    pm_evt_detect #(
        .NREQ   (NREQ),
        .TMR_W  (TMR_W),
        .LO_BIT (TMR_LO_BIT),
        .HI_BIT (TMR_HI_BIT)
    ) u_detect (
        .clk        (clk),
        .rst        (rst),
        .bm_req_n   (bm_req_n),
        .tmr_val    (tmr_val),
        .tmr_sel_hi (tmr_sel_hi),
        .bm_hit     (bm_hit),
        .tmr_toggle (tmr_toggle)
    );

    always_comb begin
        src.wake = wake_evt;
        src.ovr  = ovr_evt;
        src.rtc  = rtc_evt;
        src.slp  = slpbtn_evt;
        src.pwr  = pwrbtn_evt;
        src.glb  = fw_rel_evt;
        src.bm   = bm_hit;
        src.tmr  = tmr_toggle;
    end

    assign set_vec = src_to_vec(src);

    pm_sticky_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .stat_q  (stat)
    );

    pm_irq_gen u_irq (
        .clk   (clk),
        .rst   (rst),
        .stat  (stat),
        .en    (evt_en),
        .irq_q (irq)
    );

    assign rd_data = stat;

    // R8: any low request line sets the bus-master flag
    p_bm_set_r8: assert property (@(posedge clk) disable iff (rst)
        !(&bm_req_n) |=> rd_data[BIT_BM]);

    // R2: wake pulse reaches its fixed position
    p_wake_pos_r2: assert property (@(posedge clk) disable iff (rst)
        wake_evt |=> rd_data[BIT_WAKE]);

endmodule

// File: tb/pm_status_reg_test.sv
`timescale 1ns/100ps
module pm_status_reg_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wake_evt, rtc_evt, slpbtn_evt, pwrbtn_evt, ovr_evt, fw_rel_evt;
    logic [7:0]  bm_req_n;
    logic [31:0] tmr_val;
    logic        tmr_sel_hi;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] evt_en;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pm_status_reg uut (
        .clk(clk), .rst(rst),
        .wake_evt(wake_evt), .rtc_evt(rtc_evt), .slpbtn_evt(slpbtn_evt),
        .pwrbtn_evt(pwrbtn_evt), .ovr_evt(ovr_evt), .fw_rel_evt(fw_rel_evt),
        .bm_req_n(bm_req_n), .tmr_val(tmr_val), .tmr_sel_hi(tmr_sel_hi),
        .wr_en(wr_en), .wr_data(wr_data), .evt_en(evt_en),
        .rd_data(rd_data), .irq(irq)
    );

    // {wake, ovr, rtc, slp, pwr, glb} pulse pattern, expected read value
    localparam logic [21:0] VEC [8] = '{
        {6'b100000, 16'h8000},
        {6'b010000, 16'h0800},
        {6'b001000, 16'h0400},
        {6'b000100, 16'h0200},
        {6'b000010, 16'h0100},
        {6'b000001, 16'h0020},
        {6'b111111, 16'h8F20},
        {6'b000101, 16'h0220}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_pulses(input logic [5:0] p);
        {wake_evt, ovr_evt, rtc_evt, slpbtn_evt, pwrbtn_evt, fw_rel_evt} = p;
    endtask

    task automatic clear_all();
        wr_en = 1'b1; wr_data = 16'hFFFF;
        step();
        wr_en = 1'b0; wr_data = 16'h0000;
    endtask

    task automatic write_word(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = 16'h0000;
    endtask

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        set_pulses(6'b0);
        bm_req_n = 8'hFF; tmr_val = 32'h0; tmr_sel_hi = 1'b0;
        wr_en = 1'b0; wr_data = 16'h0; evt_en = 16'h0;
        step(); step(); step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 rd_data", rd_data, 16'h0000);
        chk("R1 irq", {15'h0, irq}, 16'h0000);

        // R2 / R10: table of pulse patterns, enables off
        for (int i = 0; i < 8; i++) begin
            clear_all();
            set_pulses(VEC[i][21:16]);
            step();
            set_pulses(6'b0);
            chk("R2 R10 pulse map", rd_data, VEC[i][15:0]);
        end

        // R3: zero writes keep flags
        clear_all();
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        write_word(16'h0000);
        chk("R3 zero write", rd_data, 16'h8000);
        write_word(16'h7FFF);
        chk("R3 other bits", rd_data, 16'h8000);
        step(); step();
        chk("R3 hold", rd_data, 16'h8000);

        // R4: selective clear
        set_pulses(6'b111111); step(); set_pulses(6'b0);
        write_word(16'h0820);
        chk("R4 selective clear", rd_data, 16'h8700);

        // R5: set beats clear in the same cycle
        rtc_evt = 1'b1; wr_en = 1'b1; wr_data = 16'h0400;
        step();
        rtc_evt = 1'b0; wr_en = 1'b0; wr_data = 16'h0;
        chk("R5 set wins", rd_data, 16'h8700);
        write_word(16'h0400);
        chk("R5 later clear", rd_data, 16'h8300);

        // R6: reserved bits stay zero with everything set
        clear_all();
        set_pulses(6'b111111); bm_req_n = 8'hFE; tmr_val = 32'h0080_0000;
        step();
        set_pulses(6'b0); bm_req_n = 8'hFF;
        chk("R6 all sources", rd_data, 16'h8F31);
        write_word(16'h70CE);
        chk("R6 reserved write", rd_data, 16'h8F31);
        tmr_val = 32'h0;
        step();
        clear_all();
        chk("R6 cleared", rd_data, 16'h0000);

        // R7: timer toggle, low select
        tmr_val = 32'h0080_0000; step();
        chk("R7 bit23 rise", rd_data, 16'h0001);
        clear_all();
        tmr_val = 32'h0000_0000; step();
        chk("R7 bit23 fall", rd_data, 16'h0001);
        clear_all();
        tmr_val = 32'h807F_FFFF; step();
        chk("R7 unwatched bits", rd_data, 16'h0000);
        tmr_val = 32'h0000_0000; step();
        clear_all();
        tmr_sel_hi = 1'b1; step();
        chk("R7 select swap", rd_data, 16'h0000);
        tmr_val = 32'h8000_0000; step();
        chk("R7 bit31 rise", rd_data, 16'h0001);
        clear_all();
        tmr_val = 32'h8080_0000; step();
        chk("R7 bit23 ignored", rd_data, 16'h0000);
        tmr_val = 32'h0080_0000; step();
        chk("R7 bit31 fall", rd_data, 16'h0001);
        tmr_val = 32'h0; step();
        tmr_sel_hi = 1'b0; step();
        clear_all();

        // R8: bus-master request lines
        step();
        chk("R8 idle", rd_data, 16'h0000);
        bm_req_n = 8'hFE; step(); bm_req_n = 8'hFF;
        chk("R8 line0", rd_data, 16'h0010);
        clear_all();
        bm_req_n = 8'h7F; step(); bm_req_n = 8'hFF;
        chk("R8 line7", rd_data, 16'h0010);

        // R9: registered interrupt
        clear_all();
        step();
        evt_en = 16'h0010;
        bm_req_n = 8'hBF; step(); bm_req_n = 8'hFF;
        chk("R9 flag set", rd_data, 16'h0010);
        chk("R9 irq lag", {15'h0, irq}, 16'h0000);
        step();
        chk("R9 irq asserted", {15'h0, irq}, 16'h0001);
        evt_en = 16'h0000; step();
        chk("R9 irq disabled", {15'h0, irq}, 16'h0000);
        evt_en = 16'h70CE; step(); step();
        chk("R9 reserved enable", {15'h0, irq}, 16'h0000);
        evt_en = 16'h8000; step(); step();
        chk("R9 mismatched enable", {15'h0, irq}, 16'h0000);
        evt_en = 16'h0010; step(); step();
        write_word(16'h0010);
        step();
        chk("R9 irq after clear", {15'h0, irq}, 16'h0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule